// File: doc/BRIEF.md
# Prefetch Pipe Fault Status Tracker

This block watches the two word slots of an instruction prefetch pipe, stage B (the slot filled first) and stage C (the slot next in line for the decoder), and watches the data bus cycles. It builds a 16-bit fault status word for the exception logic. A bus error on an instruction fetch only marks its stage as faulted. The error becomes an exception only when the decoder actually consumes that stage's word, so a fault on a word that is flushed or never used is dropped without notice. A bus error on a data cycle, or a fetch to an odd address, requests an exception in the very next cycle.

When an exception is requested, the status word and the exception type are captured and held until the exception logic acknowledges. The acknowledge clears every fault and rerun mark. Apart from that, the status word reads zero. The block also supplies the fetch addresses of the two stages from the program counter.

Top module: `pipeFaultTracker`

## Requirements
- R1: After reset, excReq is 0, excType is 0 and sswOut is 0.
- R2: stageBAddr always equals pc + 4 and stageCAddr equals pc + 2 (modulo the address width), combinationally.
- R3: busFetchReq equals fetchReq when fetchAddr bit 0 is 0 and is 0 when fetchAddr bit 0 is 1, so an odd fetch never reaches the bus.
- R4: An odd fetch is an address error. In the next cycle excReq is 1 and excType is 1 (address error). In the captured word, RC (bit 13) is set and FC (bit 15) and FB (bit 14) are not set by it. RB (bit 12) is also set only when the fetch targeted stage B (fetchToB = 1).
- R5: A completed fetch with fetchErr marks its stage as faulted: FB and RB for stage B (doneToB = 1), FC and RC for stage C. No exception follows until consumeB or consumeC hits a faulted stage. excReq then rises in the next cycle with excType 0 (bus error) and the marks in the word.
- R6: A completed data cycle with dataErr raises excReq in the next cycle, with excType 0 and DF (bit 8) set.
- R7: pipeFlush clears the fault and rerun marks of both stages without an exception, so consuming either stage afterwards raises nothing. Faults that arrive in the same cycle as the flush are kept.
- R8: pipeAdvance moves the stage B marks into stage C and leaves stage B clear. Consuming stage B afterwards raises nothing, and consuming stage C then reports FC and RC.
- R9: A data fault and a consumed fetch fault in the same cycle give one exception request with excType 0 and with DF, FC and RC all set in the word.
- R10: While excReq is 1 and excAck is 0, sswOut and excType hold and new faults start no capture. excAck clears excReq, sswOut and every mark in the next cycle. Outside an exception, sswOut reads 0.
- R11: All bits of sswOut other than 15, 14, 13, 12 and 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pc | input | ADDR_W | Program counter of the instruction in decode |
| fetchReq | input | 1 | Prefetch request for one pipe word |
| fetchAddr | input | ADDR_W | Address of the requested word |
| fetchToB | input | 1 | Request fills stage B (1) or stage C (0) |
| busFetchReq | output | 1 | Request forwarded to the bus (even addresses only) |
| fetchDone | input | 1 | Instruction bus cycle terminates |
| fetchErr | input | 1 | That termination carries a bus error |
| doneToB | input | 1 | Terminating fetch belongs to stage B (1) or C (0) |
| dataDone | input | 1 | Data bus cycle terminates |
| dataErr | input | 1 | That data termination carries a bus error |
| pipeAdvance | input | 1 | Stage B word moves into stage C |
| pipeFlush | input | 1 | Both stages are discarded |
| consumeB | input | 1 | Decoder uses the stage B word |
| consumeC | input | 1 | Decoder uses the stage C word |
| excAck | input | 1 | Exception logic has taken the status word |
| excReq | output | 1 | Exception request, held until excAck |
| excType | output | 1 | 0 = bus error, 1 = address error |
| sswOut | output | 16 | Fault status word: FC 15, FB 14, RC 13, RB 12, DF 8 |
| stageBAddr | output | ADDR_W | Fetch address of stage B |
| stageCAddr | output | ADDR_W | Fetch address of stage C |

## Verification
A mark that lands on the wrong stage, survives a flush or ack, or misses the B to C move stays hidden until a consume strobe hits that stage. It then shows as a missing or spurious excReq in the cycle after the consume, or as a wrong bit in the captured word. The bench therefore always follows a fault injection with consumes of both stages and compares excReq, excType and sswOut each cycle. A broken freeze shows as sswOut changing while excReq is held.

// File: rtl/pftPkg.sv
package pftPkg;
  localparam int SSW_W  = 16;
  localparam int POS_FC = 15;
  localparam int POS_FB = 14;
  localparam int POS_RC = 13;
  localparam int POS_RB = 12;
  localparam int POS_DF = 8;

  typedef struct packed {
    logic fC;
    logic fB;
    logic rC;
    logic rB;
  } pipeMarks_t;

  typedef struct packed {
    logic capture;
    logic clearAll;
  } pftStrobes_t;

  typedef struct packed {
    logic busFault;
    logic addrFault;
  } pftEvents_t;
endpackage

// File: rtl/pftDatapath.sv
module pftDatapath
  import pftPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pc,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchToB,
  input  logic              fetchDone,
  input  logic              fetchErr,
  input  logic              doneToB,
  input  logic              dataDone,
  input  logic              dataErr,
  input  logic              pipeAdvance,
  input  logic              pipeFlush,
  input  logic              consumeB,
  input  logic              consumeC,
  input  pftStrobes_t       strobes,
  output pftEvents_t        events,
  output logic              busFetchReq,
  output logic [SSW_W-1:0]  sswOut,
  output logic              excType,
  output logic [ADDR_W-1:0] stageBAddr,
  output logic [ADDR_W-1:0] stageCAddr
);
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_C = ADDR_W'(2);

  pipeMarks_t       marksQ, marksD, newMarks, shifted, snap;
  logic             addrFault, dataFault, usedFault;
  logic [SSW_W-1:0] wordD;

  assign stageBAddr = pc + STEP_B;
  assign stageCAddr = pc + STEP_C;

  always_comb begin
    addrFault   = fetchReq & fetchAddr[0];
    busFetchReq = fetchReq & ~fetchAddr[0];
    dataFault   = dataDone & dataErr;
    usedFault   = (consumeC & marksQ.fC) | (consumeB & marksQ.fB);

    newMarks = '0;
    if (addrFault) begin
      newMarks.rC = 1'b1;
      newMarks.rB = fetchToB;
    end
    if (fetchDone && fetchErr) begin
      if (doneToB) begin
        newMarks.fB = 1'b1;
        newMarks.rB = 1'b1;
      end else begin
        newMarks.fC = 1'b1;
        newMarks.rC = 1'b1;
      end
    end

    if (pipeFlush) begin
      shifted = '0;
    end else if (pipeAdvance) begin
      shifted.fC = marksQ.fB;
      shifted.rC = marksQ.rB;
      shifted.fB = 1'b0;
      shifted.rB = 1'b0;
    end else begin
      shifted = marksQ;
    end

    marksD = strobes.clearAll ? '0 : (shifted | newMarks);
    snap   = marksQ | newMarks;

    wordD         = '0;
    wordD[POS_FC] = snap.fC;
    wordD[POS_FB] = snap.fB;
    wordD[POS_RC] = snap.rC;
    wordD[POS_RB] = snap.rB;
    wordD[POS_DF] = dataFault;

    events.busFault  = dataFault | usedFault;
    events.addrFault = addrFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      marksQ  <= '0;
      sswOut  <= '0;
      excType <= 1'b0;
    end else begin
      marksQ <= marksD;
      if (strobes.clearAll) begin
        sswOut  <= '0;
        excType <= 1'b0;
      end else if (strobes.capture) begin
        sswOut  <= wordD;
        excType <= ~events.busFault;
      end
    end
  end

  p_fetch_fault_b_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchDone && fetchErr && doneToB && !strobes.clearAll) |=> marksQ.fB && marksQ.rB);

  p_fetch_fault_c_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchDone && fetchErr && !doneToB && !strobes.clearAll) |=> marksQ.fC && marksQ.rC);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pipeFlush && !fetchReq && !fetchDone) |=> marksQ == '0);

  p_ack_wipes_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (marksQ == '0) && (sswOut == '0));
endmodule

// File: rtl/pftCtrl.sv
module pftCtrl
  import pftPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pftEvents_t  events,
  input  logic        excAck,
  output pftStrobes_t strobes,
  output logic        excReq
);
  logic trigger;

  always_comb begin
    trigger          = events.busFault | events.addrFault;
    strobes.clearAll = excAck;
    strobes.capture  = trigger & ~excReq & ~excAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               excReq <= 1'b0;
    else if (excAck)         excReq <= 1'b0;
    else if (strobes.capture) excReq <= 1'b1;
  end

  p_req_has_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(excReq) |-> $past(events.busFault || events.addrFault));

  p_ack_drops_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    excAck |=> !excReq);

  p_req_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !excAck) |=> excReq);
endmodule

// File: rtl/pipeFaultTracker.sv
module pipeFaultTracker
  import pftPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pc,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchToB,
  output logic              busFetchReq,
  input  logic              fetchDone,
  input  logic              fetchErr,
  input  logic              doneToB,
  input  logic              dataDone,
  input  logic              dataErr,
  input  logic              pipeAdvance,
  input  logic              pipeFlush,
  input  logic              consumeB,
  input  logic              consumeC,
  input  logic              excAck,
  output logic              excReq,
  output logic              excType,
  output logic [15:0]       sswOut,
  output logic [ADDR_W-1:0] stageBAddr,
  output logic [ADDR_W-1:0] stageCAddr
);
  localparam logic [SSW_W-1:0] USED_MASK =
    SSW_W'((1 << POS_FC) | (1 << POS_FB) | (1 << POS_RC) | (1 << POS_RB) | (1 << POS_DF));

  pftStrobes_t strobes;
  pftEvents_t  events;

  pftCtrl uCtrl (
    .clk(clk), .rstN(rstN), .events(events), .excAck(excAck),
    .strobes(strobes), .excReq(excReq)
  );

  pftDatapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .pc(pc),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchToB(fetchToB),
    .fetchDone(fetchDone), .fetchErr(fetchErr), .doneToB(doneToB),
    .dataDone(dataDone), .dataErr(dataErr),
    .pipeAdvance(pipeAdvance), .pipeFlush(pipeFlush),
    .consumeB(consumeB), .consumeC(consumeC),
    .strobes(strobes), .events(events),
    .busFetchReq(busFetchReq), .sswOut(sswOut), .excType(excType),
    .stageBAddr(stageBAddr), .stageCAddr(stageCAddr)
  );

  p_word_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !excAck) |=> $stable(sswOut) && $stable(excType));

  p_idle_word_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |-> sswOut == '0);

  p_unused_bits_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sswOut & ~USED_MASK) == '0);

  p_addr_type_no_df_r4: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excType) |-> !sswOut[POS_DF]);
endmodule

// File: tb/tb_pipeFaultTracker.sv
module tb_pipeFaultTracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN;
  logic [AW-1:0] pc, fetchAddr, stageBAddr, stageCAddr;
  logic fetchReq, fetchToB, busFetchReq, fetchDone, fetchErr, doneToB;
  logic dataDone, dataErr, pipeAdvance, pipeFlush, consumeB, consumeC, excAck;
  logic excReq, excType;
  logic [15:0] sswOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // bench model state
  logic mFc, mFb, mRc, mRb, mExc, mType;
  logic [15:0] mSsw;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipeFaultTracker #(.ADDR_W(AW)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] packWord(logic fc, logic fb, logic rc, logic rb, logic df);
    packWord = '0;
    packWord[15] = fc; packWord[14] = fb; packWord[13] = rc;
    packWord[12] = rb; packWord[8]  = df;
  endfunction

  task automatic idleInputs();
    fetchReq = 0; fetchAddr = '0; fetchToB = 0; fetchDone = 0; fetchErr = 0; doneToB = 0;
    dataDone = 0; dataErr = 0; pipeAdvance = 0; pipeFlush = 0;
    consumeB = 0; consumeC = 0; excAck = 0;
  endtask

  // advance the model by one edge using the current inputs
  task automatic modelStep();
    logic nFc, nFb, nRc, nRb, addrE, dataF, busF, sFc, sFb, sRc, sRb;
    addrE = fetchReq & fetchAddr[0];
    dataF = dataDone & dataErr;
    busF  = dataF | (consumeC & mFc) | (consumeB & mFb);
    nFc = 0; nFb = 0; nRc = addrE; nRb = addrE & fetchToB;
    if (fetchDone && fetchErr) begin
      if (doneToB) begin nFb = 1; nRb = 1; end
      else begin nFc = 1; nRc = 1; end
    end
    if (pipeFlush) begin sFc = 0; sFb = 0; sRc = 0; sRb = 0; end
    else if (pipeAdvance) begin sFc = mFb; sRc = mRb; sFb = 0; sRb = 0; end
    else begin sFc = mFc; sFb = mFb; sRc = mRc; sRb = mRb; end
    if (excAck) begin
      mExc = 0; mSsw = '0; mType = 0;
      mFc = 0; mFb = 0; mRc = 0; mRb = 0;
    end else begin
      if (!mExc && (busF || addrE)) begin
        mExc = 1;
        mType = ~busF;
        mSsw = packWord(mFc | nFc, mFb | nFb, mRc | nRc, mRb | nRb, dataF);
      end
      mFc = sFc | nFc; mFb = sFb | nFb; mRc = sRc | nRc; mRb = sRb | nRb;
    end
  endtask

  // one cycle: check comb outputs, step model, clock, compare registered outputs
  task automatic cycle();
    #1;
    chk(busFetchReq === (fetchReq & ~fetchAddr[0]), "R3", busFetchReq, fetchReq & ~fetchAddr[0]);
    chk(stageBAddr === pc + 32'd4 && stageCAddr === pc + 32'd2, "R2", stageBAddr, pc + 32'd4);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk(excReq === mExc, "R5 excReq model", excReq, mExc);
    chk(excType === mType, "R4 excType model", excType, mType);
    chk(sswOut === mSsw, "R10 word model", sswOut, mSsw);
    chk((sswOut & ~16'hF100) == 16'h0, "R11", sswOut, sswOut & 16'hF100);
    idleInputs();
  endtask

  task automatic expectExc(input logic er, input logic ty, input logic [15:0] w, input string req);
    chk(excReq === er, req, excReq, er);
    if (er) chk(excType === ty, req, excType, ty);
    chk(sswOut === w, req, sswOut, w);
  endtask

  task automatic ackCycle();
    excAck = 1; cycle();
    expectExc(0, 0, 16'h0, "R10 ack clears");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    idleInputs();
    pc = 32'h0000_1000;
    mFc = 0; mFb = 0; mRc = 0; mRb = 0; mExc = 0; mType = 0; mSsw = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    expectExc(0, 0, 16'h0, "R1 reset");
    chk(excType === 1'b0, "R1 type", excType, 0);

    // R2 addresses at a wrap boundary
    pc = 32'hFFFF_FFFE; #1;
    chk(stageBAddr === 32'h0000_0002, "R2 B wrap", stageBAddr, 32'h2);
    chk(stageCAddr === 32'h0000_0000, "R2 C wrap", stageCAddr, 32'h0);
    pc = 32'h0000_1000;

    // R3 + R4 odd fetch into stage C: only RC
    fetchReq = 1; fetchAddr = 32'h2001; fetchToB = 0; #1;
    chk(busFetchReq === 1'b0, "R3 odd blocked", busFetchReq, 0);
    cycle();
    expectExc(1, 1, 16'h2000, "R4 addr err stage C");
    ackCycle();

    // R4 odd fetch into stage B: RB and RC
    fetchReq = 1; fetchAddr = 32'h2003; fetchToB = 1;
    cycle();
    expectExc(1, 1, 16'h3000, "R4 addr err stage B");
    ackCycle();

    // R3 even fetch forwarded
    fetchReq = 1; fetchAddr = 32'h2004; #1;
    chk(busFetchReq === 1'b1, "R3 even passes", busFetchReq, 1);
    cycle();
    expectExc(0, 0, 16'h0, "R3 no exc on even fetch");

    // R5 deferred stage B fault
    fetchDone = 1; fetchErr = 1; doneToB = 1; cycle();
    expectExc(0, 0, 16'h0, "R5 deferred");
    consumeC = 1; cycle();
    expectExc(0, 0, 16'h0, "R5 other stage consumed");
    consumeB = 1; cycle();
    expectExc(1, 0, 16'h5000, "R5 consume B");
    ackCycle();

    // R7 flush drops a pending fault
    fetchDone = 1; fetchErr = 1; doneToB = 0; cycle();
    pipeFlush = 1; cycle();
    consumeC = 1; consumeB = 1; cycle();
    expectExc(0, 0, 16'h0, "R7 flushed fault silent");

    // R8 advance moves B into C
    fetchDone = 1; fetchErr = 1; doneToB = 1; cycle();
    pipeAdvance = 1; cycle();
    consumeB = 1; cycle();
    expectExc(0, 0, 16'h0, "R8 B empty after advance");
    consumeC = 1; cycle();
    expectExc(1, 0, 16'hA000, "R8 C reports moved fault");
    ackCycle();

    // R9 combined data and consumed fetch fault
    fetchDone = 1; fetchErr = 1; doneToB = 0; cycle();
    dataDone = 1; dataErr = 1; consumeC = 1; cycle();
    expectExc(1, 0, 16'hA100, "R9 combined");
    // R10 frozen while held
    dataDone = 1; dataErr = 1; fetchReq = 1; fetchAddr = 32'h5; cycle();
    expectExc(1, 0, 16'hA100, "R10 frozen");
    ackCycle();
    consumeC = 1; cycle();
    expectExc(0, 0, 16'h0, "R10 marks cleared by ack");

    // R6 data fault alone
    dataDone = 1; dataErr = 1; cycle();
    expectExc(1, 0, 16'h0100, "R6 data fault");
    ackCycle();
    dataDone = 1; dataErr = 0; cycle();
    expectExc(0, 0, 16'h0, "R6 clean data cycle");

    // random phase against the bench model
    for (int i = 0; i < 4000; i++) begin
      pc          = $urandom;
      fetchReq    = ($urandom % 4) == 0;
      fetchAddr   = $urandom & ((($urandom % 6) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
      fetchToB    = $urandom % 2;
      fetchDone   = ($urandom % 4) == 0;
      fetchErr    = ($urandom % 3) == 0;
      doneToB     = $urandom % 2;
      dataDone    = ($urandom % 5) == 0;
      dataErr     = ($urandom % 6) == 0;
      pipeAdvance = ($urandom % 5) == 0;
      pipeFlush   = ($urandom % 12) == 0;
      consumeB    = ($urandom % 4) == 0;
      consumeC    = ($urandom % 4) == 0;
      excAck      = excReq && (($urandom % 3) == 0);
      cycle();
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule